// File: doc/BRIEF.md
# Module Software Reset Generator

This block drives the reset lines of many on-chip modules from a 32-bit register bus. The modules are grouped into banks of 32. Software puts a module into reset by writing a 1 to that module's bit in the bank's set register, usually after reading the register back and merging the new bit in. Software reads that same register to see which modules are held. To let a module run again, software writes a 1 to the module's bit in the bank's separate release register.

A reset must last long enough for logic clocked from the slow real-time clock (about 32 kHz) to see it. The block brings that clock into the bus clock domain through a two-flop synchroniser. For each held module it counts the synchronised rising edges. A release request that arrives too early is stored as pending. The block carries it out once enough slow edges have passed, so software can write the release at any time without waiting.

Module number n drives output bit n. That bit belongs to bank n/32, at bit position n%32.

Top module: `srst_ctrl`

## Requirements
- R1: Writing 1 to bit k of bank b's set register makes `rst_o[32*b+k]` high from the clock edge after the write.
- R2: Zero bits written to a set register leave the matching outputs unchanged. A held module is never released through its set register.
- R3: Writing 1 to bit k of bank b's release register requests release of module 32*b+k. Zero bits in that write have no effect. A release written for a module that is not held is dropped, and it does not affect a later assertion of that module.
- R4: A read of a set register returns the current reset state of its 32 modules, with 1 meaning held. Release registers and unmapped addresses read as 0.
- R5: A held module is released only after two synchronised rising edges of the slow clock have been counted since its last assertion. A release request made before that is kept pending and takes effect on the edge after the count completes. A request made after the count is complete takes effect on the next edge.
- R6: The slow clock passes through two flops before its rising edge is detected. A rise sampled at bus edge j is counted at bus edge j+2.
- R7: If a set write hits a held module in the same cycle that its release would take effect, the set wins. The module stays held, its pending release is cancelled and the edge count restarts from zero.
- R8: While the active-low reset `rst_n` is low, and after it rises, every `rst_o` bit is 0 and nothing is pending.
- R9: Set register byte addresses for banks 0 to 11 are 0x0A0, 0x0A8, 0x0B0, 0x0B8, 0x0BC, 0x0C4, 0x1C8, 0x1CC, 0x920, 0x924, 0x928 and 0x92C. The release register of bank b is at 0x940 + 4*b. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| slow_clk | input | 1 | Slow real-time clock, asynchronous to clk |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rst_o | output | 384 | Per-module reset outputs, 1 = held |

## Verification
A pending release can reach its maturity edge in the same cycle that software writes the set register for the same module. The bench provokes this by asserting a module, requesting its release at once, and then re-asserting it after a delay. The delay is swept in small steps across several slow-clock periods, so that the re-assert repeatedly lands on the cycle in which the release would complete. A behavioural model applies the set-wins rule and is compared with every output on every clock. A directed check also confirms that the module is still held two cycles after each re-assert.

// File: rtl/srst_pkg.sv
package srst_pkg;

  localparam int unsigned ADDR_W = 12;

  // Byte address of the set/status register of a bank (R9)
  function automatic logic [ADDR_W-1:0] set_reg_addr(input int unsigned bank);
    case (bank)
      0: set_reg_addr = 12'h0A0;
      1: set_reg_addr = 12'h0A8;
      2: set_reg_addr = 12'h0B0;
      3: set_reg_addr = 12'h0B8;
      4: set_reg_addr = 12'h0BC;
      5: set_reg_addr = 12'h0C4;
      6: set_reg_addr = 12'h1C8;
      7: set_reg_addr = 12'h1CC;
      default: set_reg_addr = 12'h920 + ADDR_W'(4 * (bank - 8));
    endcase
  endfunction

  // Byte address of the write-one release register of a bank (R9)
  function automatic logic [ADDR_W-1:0] rel_reg_addr(input int unsigned bank);
    rel_reg_addr = 12'h940 + ADDR_W'(4 * bank);
  endfunction

endpackage

// File: rtl/srst_sync.sv
module srst_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_tick
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_tick = sync_q & ~prev_q;
endmodule

// File: rtl/srst_decode.sv
module srst_decode
  import srst_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 12,
  parameter int unsigned BANK_W    = 32
) (
  input  logic                          wen,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BANK_W-1:0]             wdata,
  input  logic [NUM_BANKS*BANK_W-1:0]   held,
  output logic [NUM_BANKS*BANK_W-1:0]   set_mask,
  output logic [NUM_BANKS*BANK_W-1:0]   clr_mask,
  output logic [BANK_W-1:0]             rdata,
  output logic                          rd_rel_hit
);
  logic [NUM_BANKS-1:0] set_hit, rel_hit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign set_hit[b] = (addr == set_reg_addr(b));
    assign rel_hit[b] = (addr == rel_reg_addr(b));
    assign set_mask[b*BANK_W +: BANK_W] = (wen && set_hit[b]) ? wdata : '0;
    assign clr_mask[b*BANK_W +: BANK_W] = (wen && rel_hit[b]) ? wdata : '0;
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (set_hit[b]) rdata = rdata | held[b*BANK_W +: BANK_W];
    end
  end

  assign rd_rel_hit = |rel_hit;
endmodule

// File: rtl/srst_bank.sv
module srst_bank #(
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned MIN_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic [BANK_W-1:0] set_bits,
  input  logic [BANK_W-1:0] clr_bits,
  output logic [BANK_W-1:0] held,
  output logic [BANK_W-1:0] pend
);
  localparam int unsigned AGE_W = $clog2(MIN_TICKS + 1);
  localparam logic [AGE_W-1:0] AGE_DONE = AGE_W'(MIN_TICKS);

  logic [AGE_W-1:0] age [BANK_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      pend <= '0;
      for (int i = 0; i < BANK_W; i++) age[i] <= '0;
    end else begin
      for (int i = 0; i < BANK_W; i++) begin
        if (set_bits[i]) begin
          held[i] <= 1'b1;
          pend[i] <= 1'b0;
          age[i]  <= '0;
        end else if (held[i]) begin
          if ((pend[i] || clr_bits[i]) && age[i] == AGE_DONE) begin
            held[i] <= 1'b0;
            pend[i] <= 1'b0;
            age[i]  <= '0;
          end else begin
            pend[i] <= pend[i] | clr_bits[i];
            if (slow_tick && age[i] != AGE_DONE) age[i] <= age[i] + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
  import srst_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 12,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned MIN_TICKS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        slow_clk,
  input  logic                        bus_wen,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [BANK_W-1:0]           bus_rdata,
  output logic [NUM_BANKS*BANK_W-1:0] rst_o
);
  localparam int unsigned NMOD = NUM_BANKS * BANK_W;

  logic            slow_tick;
  logic [NMOD-1:0] set_mask, clr_mask, held, pend;
  logic            rd_rel_hit;

  srst_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(slow_clk), .rise_tick(slow_tick)
  );

  srst_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dec (
    .wen(bus_wen), .addr(bus_addr), .wdata(bus_wdata), .held(held),
    .set_mask(set_mask), .clr_mask(clr_mask),
    .rdata(bus_rdata), .rd_rel_hit(rd_rel_hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    srst_bank #(.BANK_W(BANK_W), .MIN_TICKS(MIN_TICKS)) u_bank (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
      .set_bits(set_mask[b*BANK_W +: BANK_W]),
      .clr_bits(clr_mask[b*BANK_W +: BANK_W]),
      .held(held[b*BANK_W +: BANK_W]),
      .pend(pend[b*BANK_W +: BANK_W])
    );
  end

  assign rst_o = held;
endmodule

// File: rtl/srst_ctrl_chk.sv
module srst_ctrl_chk #(
  parameter int unsigned NMOD      = 384,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned MIN_TICKS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NMOD-1:0]   rst_o,
  input logic [NMOD-1:0]   set_mask,
  input logic [NMOD-1:0]   clr_mask,
  input logic [NMOD-1:0]   pend,
  input logic              slow_tick,
  input logic              rd_rel_hit,
  input logic [BANK_W-1:0] rdata
);
  localparam int unsigned CW = $clog2(MIN_TICKS + 1);
  logic [CW-1:0] cnt [NMOD];
  logic [NMOD-1:0] aged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NMOD; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < NMOD; i++) begin
        if (set_mask[i]) cnt[i] <= '0;
        else if (slow_tick && rst_o[i] && cnt[i] != CW'(MIN_TICKS)) cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NMOD; i++) aged[i] = (cnt[i] == CW'(MIN_TICKS));
  end

  AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> ((rst_o & $past(set_mask)) == $past(set_mask))); // R7

  AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((rst_o & ~$past(rst_o) & ~$past(set_mask)) == '0)); // R1

  AST_FALL_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    ((~rst_o & $past(rst_o) & ~$past(pend | clr_mask)) == '0)); // R3

  AST_FALL_AFTER_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ((~rst_o & $past(rst_o) & ~$past(aged)) == '0)); // R5

  AST_PEND_ONLY_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~rst_o) == '0)); // R3

  AST_REL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rel_hit |-> (rdata == '0)); // R4
endmodule

bind srst_ctrl srst_ctrl_chk #(
  .NMOD(NUM_BANKS * BANK_W), .BANK_W(BANK_W), .MIN_TICKS(MIN_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_o(rst_o), .set_mask(set_mask),
  .clr_mask(clr_mask), .pend(pend), .slow_tick(slow_tick),
  .rd_rel_hit(rd_rel_hit), .rdata(bus_rdata)
);

// File: tb/srst_ctrl_test.sv
module srst_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 12;
  localparam int BW = 32;
  localparam int NM = NB * BW;
  localparam int SLOW_HALF = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slow_clk = 1'b0;
  logic          bus_wen = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NM-1:0] rst_o;

  int compared = 0;
  int mismatched = 0;

  srst_ctrl uut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_o(rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (SLOW_HALF) @(negedge clk);
      slow_clk = ~slow_clk;
    end
  end

  // Reference model, written from the requirements
  int set_off [NB] = '{'h0A0, 'h0A8, 'h0B0, 'h0B8, 'h0BC, 'h0C4,
                       'h1C8, 'h1CC, 'h920, 'h924, 'h928, 'h92C};
  bit [NM-1:0] m_held, m_pend;
  int m_age [NM];
  bit h1, h2, h3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_held = '0; m_pend = '0; h1 = 0; h2 = 0; h3 = 0;
      foreach (m_age[i]) m_age[i] = 0;
    end else begin
      bit tick;
      tick = h2 && !h3;          // R6: seen two edges after sampling
      for (int i = 0; i < NM; i++) begin
        int b, k;
        bit s, c;
        b = i / BW; k = i % BW;
        s = bus_wen && (int'(bus_addr) == set_off[b]) && bus_wdata[k];
        c = bus_wen && (int'(bus_addr) == 'h940 + 4*b) && bus_wdata[k];
        if (s) begin
          m_held[i] = 1; m_pend[i] = 0; m_age[i] = 0;
        end else if (m_held[i]) begin
          if ((m_pend[i] || c) && m_age[i] >= 2) begin
            m_held[i] = 0; m_pend[i] = 0; m_age[i] = 0;
          end else begin
            m_pend[i] = m_pend[i] || c;
            if (tick && m_age[i] < 2) m_age[i]++;
          end
        end
      end
      h3 = h2; h2 = h1; h1 = slow_clk;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      compared++;
      if (rst_o !== m_held) begin
        mismatched++;
        $display("FAIL R1/R3/R5/R7 per-cycle rst_o actual=%h expected=%h", rst_o, m_held);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd_check(input string tag, input int a, input logic [31:0] exp);
    bus_addr = 12'(a);
    #1;
    check(tag, bus_rdata, exp);
    bus_addr = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [NM-1:0] snap;
    #(CLK_PERIOD * 3);
    check("R8 reset state", 32'(rst_o != '0), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R8 after reset", 32'(rst_o != '0), 32'd0);

    // R1: set bits 0 and 2 of bank 0
    wr('h0A0, 32'h5);
    check("R1 set bit 2", 32'(rst_o[2]), 32'd1);
    rd_check("R4 read set reg", 'h0A0, 32'h5);
    // R2: zeros do not release
    wr('h0A0, 32'h0);
    rd_check("R2 zero write keeps state", 'h0A0, 32'h5);
    // R5: early release is held pending
    wr('h940, 32'h1);
    repeat (3) @(negedge clk);
    check("R5 early release pending", 32'(rst_o[0]), 32'd1);
    repeat (150) @(negedge clk);
    check("R3 R5 released later", 32'(rst_o[0]), 32'd0);
    check("R3 zero bits no effect", 32'(rst_o[2]), 32'd1);
    // R3: release of a module not held is dropped
    wr('h940, 32'h10);
    wr('h0A0, 32'h10);
    repeat (200) @(negedge clk);
    check("R3 stale release dropped", 32'(rst_o[4]), 32'd1);
    // R3 R5: release after min width completes on next edge
    wr('h940, 32'h10);
    check("R3 aged release immediate", 32'(rst_o[4]), 32'd0);

    // R9: bank 6 and bank 11
    wr('h1C8, 32'h8000_0000);
    check("R9 R1 module 223", 32'(rst_o[223]), 32'd1);
    rd_check("R4 read bank 6", 'h1C8, 32'h8000_0000);
    rd_check("R4 release reg reads 0", 'h958, 32'h0);
    rd_check("R4 unmapped reads 0", 'h004, 32'h0);
    snap = rst_o;
    wr('h004, 32'hFFFF_FFFF);
    wr('h944, 32'h0);
    check("R9 unmapped write ignored", 32'(rst_o != snap), 32'd0);
    wr('h92C, 32'h80);
    check("R9 R1 module 359", 32'(rst_o[359]), 32'd1);
    repeat (150) @(negedge clk);
    wr('h96C, 32'h80);
    check("R9 R3 release bank 11", 32'(rst_o[359]), 32'd0);

    // R7: re-set colliding with maturing release, swept
    for (int d = 0; d < 200; d += 3) begin
      wr('h0B8, 32'h10);
      wr('h94C, 32'h10);
      repeat (d) @(negedge clk);
      wr('h0B8, 32'h10);
      @(negedge clk);
      check("R7 set wins", 32'(rst_o[100]), 32'd1);
      wr('h94C, 32'h10);
      repeat (120) @(negedge clk);
    end
    check("R7 final release", 32'(rst_o[100]), 32'd0);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule